// File: doc/BRIEF.md
# Multithreaded Decode Flow Controller

This block steers instructions through the decode stage of a multithreaded superscalar core. Each cycle it takes a bundle from fetch. Every slot in the bundle carries a thread number, a sequence number, a squashed mark and a zero-source mark. The block forwards at most a fixed number of survivors to rename. Threads are served in ascending order and share those output slots. Opcode decoding itself is not part of the block.

Each thread runs its own five-state controller. Three downstream stages (rename, issue/execute, commit) can stall a thread with block and unblock pulses. Commit can also squash a thread or hold it in a squashing phase. Anything a thread cannot pass on goes into that thread's skid store. The skid store holds (fetch-to-decode latency × fetch width + decode width) entries. When the stall lifts, the thread drains the skid store before it touches new fetch input. It only tells fetch to release once that store is empty. Hold and release requests go back to fetch as per-thread pulses.

All outputs are registered. A result appears in the cycle after the edge that sampled its inputs.

Top module: `decode_flow`

## Requirements
- R1: After reset every thread is Idle (state code 0), all stall flags are clear, and `dec_size`, `fe_hold`, `fe_release` and `err` are zero. The state codes are Idle 0, Running 1, Blocked 2, Unblocking 3 and Squashing 4, with thread t at `thr_state[3t+:3]`.
- R2: Each thread has three stall flags, one per stage (rename, issue/execute, commit). A block pulse sets its flag, and an unblock pulse in the same or a later cycle clears it. A thread stays Blocked while any of its flags is set.
- R3: Each thread resolves its events in this priority order, highest first:
  - a commit squash;
  - commit still squashing (which discards that cycle's input and enters Squashing);
  - any stall flag set;
  - Blocked moving on (to Unblocking, or straight to Running when the skid store is empty);
  - Squashing moving to Running.
- R4: When a stall flag is set, the thread's input for that cycle is appended to its skid store. `fe_hold[t]` pulses only if the thread was not already Blocked.
- R5: In Unblocking, output comes from the head of the skid store and that cycle's input is appended behind it. When the store ends a cycle empty, the thread becomes Running and `fe_release[t]` pulses.
- R6: At most DW instructions are emitted per cycle. Thread 0 is served before thread 1, and each thread's instructions keep their order. Slot i sits at `dec_seq[i*SW+:SW]` and `dec_tid[i*TW+:TW]`. Slots at or above `dec_size` carry zero. An instruction marked squashed is dropped without taking a slot.
- R7: If a thread still has instructions after the slots run out, the leftovers go to its skid store, the thread enters Blocked and `fe_hold[t]` pulses.
- R8: A commit squash discards the thread's skid store and its input for that cycle, and enters Squashing. `fe_release[t]` pulses if the thread was Blocked or Unblocking.
- R9: Output slot i has `dec_rdy[i]` equal to the zero-source mark of the instruction in it.
- R10: `err` sets and stays set until reset in either of two cases:
  - an append would exceed the skid capacity, in which case the excess entry is discarded;
  - an unblock pulse arrives for a flag that is neither set nor being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_size | input | CW | Number of valid fetch slots, starting at slot 0 |
| fe_tid | input | FW*TW | Thread number per fetch slot |
| fe_seq | input | FW*SW | Sequence number per fetch slot |
| fe_sqd | input | FW | Squashed mark per fetch slot |
| fe_nosrc | input | FW | Zero-source mark per fetch slot |
| ren_blk | input | NT | Rename block pulse per thread |
| ren_unb | input | NT | Rename unblock pulse per thread |
| ix_blk | input | NT | Issue/execute block pulse per thread |
| ix_unb | input | NT | Issue/execute unblock pulse per thread |
| cm_blk | input | NT | Commit block pulse per thread |
| cm_unb | input | NT | Commit unblock pulse per thread |
| cm_sq | input | NT | Commit squash per thread |
| cm_busy | input | NT | Commit still squashing per thread |
| dec_size | output | OW | Number of valid rename slots |
| dec_tid | output | DW*TW | Thread number per rename slot |
| dec_seq | output | DW*SW | Sequence number per rename slot |
| dec_rdy | output | DW | Ready-to-issue mark per rename slot |
| fe_hold | output | NT | Hold request pulse to fetch per thread |
| fe_release | output | NT | Release request pulse to fetch per thread |
| thr_state | output | NT*3 | State code per thread |
| err | output | 1 | Sticky protocol or overflow error |

## Verification
The random phase mixes fetch bundles of zero to full width across both threads, and sprinkles in squashed slots, stall pulses, squashes and squash-hold cycles. These patterns separate several cases:
- a thread that drains its skid store from one that wrongly reads fresh input;
- thread 0 taking output slots ahead of thread 1;
- leftovers that force a block.

Random fetch is limited so the skid store never overflows. Directed sequences then cover the rest:
- a squash or a squash-hold arriving together with a block pulse, to show the priority;
- a full block, wait, release and drain cycle, to show that release waits for an empty store;
- a deliberate overflow, and an unblock pulse on a clear flag, to show that the error is sticky.

// File: rtl/decode_flow.sv
module decode_flow #(
  parameter int NT    = 2,
  parameter int FW    = 2,
  parameter int DW    = 2,
  parameter int FDLAT = 1,
  parameter int SW    = 8,
  localparam int TW  = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW  = $clog2(FW + 1),
  localparam int OW  = $clog2(DW + 1),
  localparam int SKD = FDLAT * FW + DW,
  localparam int KW  = $clog2(SKD + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     fe_size,
  input  logic [FW*TW-1:0]  fe_tid,
  input  logic [FW*SW-1:0]  fe_seq,
  input  logic [FW-1:0]     fe_sqd,
  input  logic [FW-1:0]     fe_nosrc,
  input  logic [NT-1:0]     ren_blk,
  input  logic [NT-1:0]     ren_unb,
  input  logic [NT-1:0]     ix_blk,
  input  logic [NT-1:0]     ix_unb,
  input  logic [NT-1:0]     cm_blk,
  input  logic [NT-1:0]     cm_unb,
  input  logic [NT-1:0]     cm_sq,
  input  logic [NT-1:0]     cm_busy,
  output logic [OW-1:0]     dec_size,
  output logic [DW*TW-1:0]  dec_tid,
  output logic [DW*SW-1:0]  dec_seq,
  output logic [DW-1:0]     dec_rdy,
  output logic [NT-1:0]     fe_hold,
  output logic [NT-1:0]     fe_release,
  output logic [NT*3-1:0]   thr_state,
  output logic              err
);
  typedef enum logic [2:0] {S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2, S_UNB = 3'd3, S_SQ = 3'd4} st_e;
  typedef struct packed { logic [SW-1:0] seq; logic sq; logic ns; } ent_t;

  st_e           st [NT], st_n [NT];
  logic [2:0]    flg [NT], flg_n [NT];
  ent_t          skid [NT][SKD], skid_n [NT][SKD];
  logic [KW-1:0] cnt [NT], cnt_n [NT];
  ent_t          fin [FW];
  logic [TW-1:0] ftid [FW];

  logic [OW-1:0] size_n, size_q;
  logic [TW-1:0] otid_n [DW], otid_q [DW];
  logic [SW-1:0] oseq_n [DW], oseq_q [DW];
  logic          ordy_n [DW], ordy_q [DW];
  logic [NT-1:0] hold_n, rel_n, hold_q, rel_q;
  logic          err_n, err_q;

  for (genvar i = 0; i < FW; i++) begin : g_in
    assign fin[i]  = '{seq: fe_seq[i*SW +: SW], sq: fe_sqd[i], ns: fe_nosrc[i]};
    assign ftid[i] = fe_tid[i*TW +: TW];
  end

  for (genvar i = 0; i < DW; i++) begin : g_out
    assign dec_tid[i*TW +: TW] = otid_q[i];
    assign dec_seq[i*SW +: SW] = oseq_q[i];
    assign dec_rdy[i]          = ordy_q[i];
  end

  for (genvar t = 0; t < NT; t++) begin : g_st
    assign thr_state[t*3 +: 3] = st[t];
  end

  assign dec_size   = size_q;
  assign fe_hold    = hold_q;
  assign fe_release = rel_q;
  assign err        = err_q;

  always_comb begin
    int   used, wc, pc, k;
    logic left;
    ent_t w [SKD];
    ent_t pend [FW];
    st_e  s;
    logic [2:0] f, b, u;
    used = 0; hold_n = '0; rel_n = '0; err_n = err_q;
    for (int i = 0; i < DW; i++) begin otid_n[i] = '0; oseq_n[i] = '0; ordy_n[i] = 1'b0; end
    for (int t = 0; t < NT; t++) begin
      b = {cm_blk[t], ix_blk[t], ren_blk[t]};
      u = {cm_unb[t], ix_unb[t], ren_unb[t]};
      if ((u & ~(flg[t] | b)) != 3'b000) err_n = 1'b1;
      f = (flg[t] | b) & ~u;
      flg_n[t] = f;
      pc = 0;
      for (int i = 0; i < FW; i++) pend[i] = '0;
      for (int i = 0; i < FW; i++)
        if (i < int'(fe_size) && int'(ftid[i]) == t) begin pend[pc] = fin[i]; pc++; end
      for (int j = 0; j < SKD; j++) w[j] = skid[t][j];
      wc = int'(cnt[t]); s = st[t]; k = 0; left = 1'b0;
      if (cm_sq[t]) begin
        if (s == S_BLK || s == S_UNB) rel_n[t] = 1'b1;
        s = S_SQ; wc = 0;
      end else if (cm_busy[t]) begin
        s = S_SQ;
      end else if (f != 3'b000) begin
        for (int i = 0; i < FW; i++)
          if (i < pc) begin
            if (wc < SKD) begin w[wc] = pend[i]; wc++; end else err_n = 1'b1;
          end
        if (s != S_BLK) begin s = S_BLK; hold_n[t] = 1'b1; end
      end else begin
        if (s == S_BLK) begin
          if (wc == 0) begin s = S_RUN; rel_n[t] = 1'b1; end else s = S_UNB;
        end else if (s == S_SQ) s = S_RUN;
        if (s == S_UNB) begin
          for (int j = 0; j < SKD; j++)
            if (j < wc && used < DW) begin
              k++;
              if (!w[j].sq) begin
                oseq_n[used] = w[j].seq; otid_n[used] = TW'(t); ordy_n[used] = w[j].ns; used++;
              end
            end
          for (int j = 0; j < SKD; j++) w[j] = (j + k < SKD) ? w[j + k] : '0;
          wc = wc - k;
          left = (wc != 0);
          for (int i = 0; i < FW; i++)
            if (i < pc) begin
              if (wc < SKD) begin w[wc] = pend[i]; wc++; end else err_n = 1'b1;
            end
          if (left) begin s = S_BLK; hold_n[t] = 1'b1; end
          else if (wc == 0) begin s = S_RUN; rel_n[t] = 1'b1; end
        end else begin
          for (int i = 0; i < FW; i++)
            if (i < pc && used < DW) begin
              k++;
              if (!pend[i].sq) begin
                oseq_n[used] = pend[i].seq; otid_n[used] = TW'(t); ordy_n[used] = pend[i].ns; used++;
              end
            end
          if (k < pc) begin
            for (int i = 0; i < FW; i++)
              if (i >= k && i < pc) begin
                if (wc < SKD) begin w[wc] = pend[i]; wc++; end else err_n = 1'b1;
              end
            s = S_BLK; hold_n[t] = 1'b1;
          end
        end
      end
      st_n[t] = s;
      cnt_n[t] = KW'(wc);
      for (int j = 0; j < SKD; j++) skid_n[t][j] = w[j];
    end
    size_n = OW'(used);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        st[t] <= S_IDLE; flg[t] <= '0; cnt[t] <= '0;
        for (int j = 0; j < SKD; j++) skid[t][j] <= '0;
      end
      for (int i = 0; i < DW; i++) begin otid_q[i] <= '0; oseq_q[i] <= '0; ordy_q[i] <= 1'b0; end
      size_q <= '0; hold_q <= '0; rel_q <= '0; err_q <= 1'b0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        st[t] <= st_n[t]; flg[t] <= flg_n[t]; cnt[t] <= cnt_n[t];
        for (int j = 0; j < SKD; j++) skid[t][j] <= skid_n[t][j];
      end
      for (int i = 0; i < DW; i++) begin otid_q[i] <= otid_n[i]; oseq_q[i] <= oseq_n[i]; ordy_q[i] <= ordy_n[i]; end
      size_q <= size_n; hold_q <= hold_n; rel_q <= rel_n; err_q <= err_n;
    end
  end
endmodule

// File: rtl/decode_flow_chk.sv
module decode_flow_chk #(
  parameter int NT = 2,
  parameter int DW = 2,
  localparam int OW = $clog2(DW + 1)
)(
  input logic            clk,
  input logic            rst_n,
  input logic [OW-1:0]   dec_size,
  input logic [NT-1:0]   fe_hold,
  input logic [NT-1:0]   fe_release,
  input logic [NT*3-1:0] thr_state,
  input logic [NT-1:0]   cm_sq,
  input logic            err
);
  assert_slot_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dec_size) <= DW);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      thr_state[t*3 +: 3] <= 3'd4);
    assert_hold_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fe_hold[t] |-> thr_state[t*3 +: 3] == 3'd2);
    assert_release_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fe_release[t] |-> (thr_state[t*3 +: 3] != 3'd0 && thr_state[t*3 +: 3] != 3'd3));
    assert_squash_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cm_sq[t] |=> thr_state[t*3 +: 3] == 3'd4);
  end
endmodule

bind decode_flow decode_flow_chk #(.NT(NT), .DW(DW)) u_decode_flow_chk (
  .clk(clk), .rst_n(rst_n), .dec_size(dec_size), .fe_hold(fe_hold),
  .fe_release(fe_release), .thr_state(thr_state), .cm_sq(cm_sq), .err(err)
);

// File: tb/test_decode_flow.sv
module test_decode_flow;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, FW = 2, DW = 2, FDLAT = 1, SW = 8;
  localparam int TW = 1, CW = 2, OW = 2, SKD = FDLAT * FW + DW;

  typedef struct { logic [SW-1:0] seq; bit sq; bit ns; } e_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] fe_size; logic [FW*TW-1:0] fe_tid; logic [FW*SW-1:0] fe_seq;
  logic [FW-1:0] fe_sqd, fe_nosrc;
  logic [NT-1:0] ren_blk, ren_unb, ix_blk, ix_unb, cm_blk, cm_unb, cm_sq, cm_busy;
  logic [OW-1:0] dec_size; logic [DW*TW-1:0] dec_tid; logic [DW*SW-1:0] dec_seq;
  logic [DW-1:0] dec_rdy; logic [NT-1:0] fe_hold, fe_release; logic [NT*3-1:0] thr_state;
  logic err;

  int in_n; int in_tid [FW]; e_t in_e [FW];
  bit [NT-1:0] p_rb, p_ru, p_ib, p_iu, p_cb, p_cu, p_sq, p_busy;

  e_t sk [NT][$]; int ms [NT]; bit [2:0] mf [NT]; bit merr;
  int x_size; logic [SW-1:0] x_seq [DW]; int x_tid [DW]; bit x_rdy [DW];
  bit [NT-1:0] x_hold, x_rel;
  int checks = 0, fails = 0;
  logic [SW-1:0] seqc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    fe_size = CW'(in_n);
    for (int i = 0; i < FW; i++) begin
      fe_tid[i*TW +: TW] = TW'(in_tid[i]);
      fe_seq[i*SW +: SW] = in_e[i].seq;
      fe_sqd[i] = in_e[i].sq;
      fe_nosrc[i] = in_e[i].ns;
    end
    ren_blk = p_rb; ren_unb = p_ru; ix_blk = p_ib; ix_unb = p_iu;
    cm_blk = p_cb; cm_unb = p_cu; cm_sq = p_sq; cm_busy = p_busy;
  end

  decode_flow #(.NT(NT), .FW(FW), .DW(DW), .FDLAT(FDLAT), .SW(SW)) i_decode_flow (
    .clk(clk), .rst_n(rst_n), .fe_size(fe_size), .fe_tid(fe_tid), .fe_seq(fe_seq),
    .fe_sqd(fe_sqd), .fe_nosrc(fe_nosrc), .ren_blk(ren_blk), .ren_unb(ren_unb),
    .ix_blk(ix_blk), .ix_unb(ix_unb), .cm_blk(cm_blk), .cm_unb(cm_unb), .cm_sq(cm_sq),
    .cm_busy(cm_busy), .dec_size(dec_size), .dec_tid(dec_tid), .dec_seq(dec_seq),
    .dec_rdy(dec_rdy), .fe_hold(fe_hold), .fe_release(fe_release),
    .thr_state(thr_state), .err(err));

  function automatic void clear_in();
    in_n = 0;
    for (int i = 0; i < FW; i++) begin in_tid[i] = 0; in_e[i] = '{seq: '0, sq: 1'b0, ns: 1'b0}; end
    p_rb = '0; p_ru = '0; p_ib = '0; p_iu = '0; p_cb = '0; p_cu = '0; p_sq = '0; p_busy = '0;
  endfunction

  function automatic void add_in(int t, bit sq, bit ns);
    in_tid[in_n] = t; in_e[in_n] = '{seq: seqc, sq: sq, ns: ns};
    seqc = seqc + 1'b1; in_n++;
  endfunction

  function automatic void skpush(int t, e_t e);
    if (sk[t].size() < SKD) sk[t].push_back(e); else merr = 1'b1;
  endfunction

  function automatic void emit(ref int used, input int t, input e_t e);
    x_seq[used] = e.seq; x_tid[used] = t; x_rdy[used] = e.ns; used++;
  endfunction

  function automatic void model();
    int used; e_t e; e_t pend[$]; bit [2:0] b, u; int s; bit left;
    used = 0; x_hold = '0; x_rel = '0;
    for (int i = 0; i < DW; i++) begin x_seq[i] = '0; x_tid[i] = 0; x_rdy[i] = 1'b0; end
    for (int t = 0; t < NT; t++) begin
      pend = {};
      for (int i = 0; i < in_n; i++) if (in_tid[i] == t) pend.push_back(in_e[i]);
      b = {p_cb[t], p_ib[t], p_rb[t]}; u = {p_cu[t], p_iu[t], p_ru[t]};
      if ((u & ~(mf[t] | b)) != 3'b000) merr = 1'b1;
      mf[t] = (mf[t] | b) & ~u;
      s = ms[t];
      if (p_sq[t]) begin
        if (s == 2 || s == 3) x_rel[t] = 1'b1;
        s = 4; sk[t] = {};
      end else if (p_busy[t]) s = 4;
      else if (mf[t] != 3'b000) begin
        foreach (pend[i]) skpush(t, pend[i]);
        if (s != 2) begin s = 2; x_hold[t] = 1'b1; end
      end else begin
        if (s == 2) begin
          if (sk[t].size() == 0) begin s = 1; x_rel[t] = 1'b1; end else s = 3;
        end else if (s == 4) s = 1;
        if (s == 3) begin
          while (sk[t].size() > 0 && used < DW) begin
            e = sk[t].pop_front(); if (!e.sq) emit(used, t, e);
          end
          left = sk[t].size() > 0;
          foreach (pend[i]) skpush(t, pend[i]);
          if (left) begin s = 2; x_hold[t] = 1'b1; end
          else if (sk[t].size() == 0) begin s = 1; x_rel[t] = 1'b1; end
        end else begin
          while (pend.size() > 0 && used < DW) begin
            e = pend.pop_front(); if (!e.sq) emit(used, t, e);
          end
          if (pend.size() > 0) begin
            foreach (pend[i]) skpush(t, pend[i]);
            s = 2; x_hold[t] = 1'b1;
          end
        end
      end
      ms[t] = s;
    end
    x_size = used;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("R6 dec_size", int'(dec_size), x_size);
    for (int i = 0; i < DW; i++) begin
      cmp("R6 slot seq", int'(dec_seq[i*SW +: SW]), int'(x_seq[i]));
      cmp("R6 slot tid", int'(dec_tid[i*TW +: TW]), x_tid[i]);
      cmp("R9 slot ready", int'(dec_rdy[i]), int'(x_rdy[i]));
    end
    cmp("R4 R7 fe_hold", int'(fe_hold), int'(x_hold));
    cmp("R5 R8 fe_release", int'(fe_release), int'(x_rel));
    for (int t = 0; t < NT; t++) cmp("R2 R3 thread state", int'(thr_state[t*3 +: 3]), ms[t]);
    cmp("R10 err", int'(err), int'(merr));
  endtask

  task automatic tick();
    model();
    @(posedge clk);
    @(negedge clk);
    check_all();
    clear_in();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clear_in();
    for (int t = 0; t < NT; t++) begin sk[t] = {}; ms[t] = 0; mf[t] = 3'b000; end
    merr = 1'b0; x_size = 0; x_hold = '0; x_rel = '0;
    for (int i = 0; i < DW; i++) begin x_seq[i] = '0; x_tid[i] = 0; x_rdy[i] = 1'b0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  task automatic rnd_in();
    int n, t, cnt_t [NT];
    for (int i = 0; i < NT; i++) cnt_t[i] = 0;
    n = $urandom_range(0, FW);
    for (int i = 0; i < n; i++) begin
      t = $urandom_range(0, NT - 1);
      if (sk[t].size() + cnt_t[t] + 1 <= SKD) begin
        add_in(t, $urandom_range(0, 5) == 0, 1'($urandom_range(0, 1)));
        cnt_t[t]++;
      end
    end
    for (int t2 = 0; t2 < NT; t2++) begin
      p_rb[t2] = $urandom_range(0, 11) == 0; p_ru[t2] = mf[t2][0] && $urandom_range(0, 2) == 0;
      p_ib[t2] = $urandom_range(0, 11) == 0; p_iu[t2] = mf[t2][1] && $urandom_range(0, 2) == 0;
      p_cb[t2] = $urandom_range(0, 11) == 0; p_cu[t2] = mf[t2][2] && $urandom_range(0, 2) == 0;
      p_sq[t2] = $urandom_range(0, 24) == 0; p_busy[t2] = $urandom_range(0, 19) == 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_in();
    do_reset();
    // R1 reset state checked by do_reset; random mix covers R2..R9
    for (int c = 0; c < 3000; c++) begin rnd_in(); tick(); end

    // R3 priority: squash beats block on t0, squash-hold beats block on t1
    do_reset();
    p_sq[0] = 1'b1; p_rb[0] = 1'b1; p_busy[1] = 1'b1; p_ib[1] = 1'b1; add_in(0, 1'b0, 1'b1); tick();
    p_ru[0] = 1'b1; p_iu[1] = 1'b1; tick();
    tick();

    // R4 R5 R7: block with input, wait, release, drain skid before fresh input
    do_reset();
    p_rb[0] = 1'b1; add_in(0, 1'b0, 1'b0); add_in(0, 1'b0, 1'b1); tick();
    tick();
    p_ru[0] = 1'b1; add_in(0, 1'b1, 1'b0); add_in(0, 1'b0, 1'b0); tick();
    add_in(1, 1'b0, 1'b1); add_in(1, 1'b0, 1'b0); tick();
    tick(); tick();

    // R8: squash while Blocked releases fetch and empties skid
    do_reset();
    p_cb[1] = 1'b1; add_in(1, 1'b0, 1'b0); tick();
    p_cu[1] = 1'b1; p_sq[1] = 1'b1; tick();
    add_in(1, 1'b0, 1'b1); tick();
    tick();

    // R10 overflow of skid capacity
    do_reset();
    p_ib[0] = 1'b1; add_in(0, 1'b0, 1'b0); add_in(0, 1'b0, 1'b0); tick();
    add_in(0, 1'b0, 1'b0); add_in(0, 1'b0, 1'b0); tick();
    add_in(0, 1'b0, 1'b0); tick();
    p_iu[0] = 1'b1; tick();
    repeat (4) tick();

    // R10 unblock pulse for a clear flag
    do_reset();
    p_cu[1] = 1'b1; tick();
    tick();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule